// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for one display interface. One pixel-clock counter runs over the whole frame. Vertical quantities are therefore set as pixel-clock offsets inside the frame, not as line numbers. A second counter gives the position inside the line, and the horizontal quantities are set against it. From these two counters the block drives horizontal sync, vertical sync and a data-enable strobe. It also drives a pixel bus. Inside the active window the pixel bus carries the upstream pixel. When upstream has no pixel ready, it carries a programmable fill colour. Outside the window it carries a programmable border colour.

Software programs the block through a simple synchronous write port and reads it back through a combinational read port. Timing, polarity and colour registers are double-buffered. A write goes first to a pending copy. The working copy used by the counters and outputs takes that value at the next frame wrap, or on every cycle while the engine is stopped. The engine-enable bit is only looked at when the engine is idle or at a frame wrap. After software clears it, the current frame runs to its end. A line counter and a frame counter are readable, and each has its own count-enable bit.

The control is a two-state machine. ST_IDLE holds the counters at zero and the outputs inactive. ST_RUN advances the counters. The transition IDLE_TO_RUN is taken on the first cycle in which the pending enable bit is 1. The transition RUN_TO_IDLE is taken at a frame wrap while the pending enable bit is 0. Otherwise the state holds (IDLE_HOLD, RUN_HOLD).

Top module: `vid_timing_gen`

## Requirements
- R1: After reset, the read port returns these values: line period 8, hsync width 2, horizontal window 3..6, frame period 48, vsync length 8, vertical window 16..39, polarity 0, fill colour 0xFF, border colour 0, enable 0, count enable 0, panel format 0x213F (bits [5:0] give depth: 0x00=4, 0x15=5, 0x2A=6, 0x3F=8 bits). The engine is idle, hsync_o, vsync_o and de_o are 0, and pix_o shows the border colour.
- R2: While running, the in-line position counts 0..P-1, where P is the line period at address 0. It restarts at 0 after P-1 and at every frame wrap. Sync is active while the position is below the hsync width at address 1.
- R3: While running, the frame counter counts 0..F-1, where F is the frame period at address 4, then wraps to 0. Vsync is active while the count is below the vsync length at address 5.
- R4: de_o is 1 exactly when the engine runs, the frame count lies in [address 6, address 7] and the in-line position lies in [address 2, address 3], all bounds inclusive.
- R5: pix_o equals pix_i when de_o=1 and pix_valid_i=1. It equals the fill colour (address 9) when de_o=1 and pix_valid_i=0. It equals the border colour (address 10) when de_o=0.
- R6: Polarity register (address 8): bit 0 set makes hsync_o active-low and bit 1 set makes vsync_o active-low. While idle, each sync output sits at its inactive level, which equals its polarity bit.
- R7: Enable (address 11, bit 0). Setting it starts the engine at frame count 0 on the next cycle. Clearing it while running lets the current frame finish, and the engine goes idle at the frame wrap.
- R8: Writes to addresses 0-10 made while running are read back at once but reach the outputs only from the next frame wrap on.
- R9: The line count (read at address 14) is the number of lines completed in the current frame and resets at each frame wrap. The frame count (read at address 15) increments at each frame wrap. Count enable (address 12) bit 0 gates the line count and bit 1 gates the frame count. A gated counter holds its value.
- R10: The read port returns the last written value of each address 0-13, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| pix_i | input | 24 | Upstream pixel |
| pix_valid_i | input | 1 | Upstream pixel present |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| pix_o | output | 24 | Output pixel |

## Verification
The assertions assume that every programmed frame period and line period is at least 1. They also assume that the frame period is at least the value already reached by the running counter only after it has been loaded at a wrap; the double buffering provides this, because the working copy only changes at a wrap. The bench programs a 10-pixel, 5-line frame with the engine idle and keeps every window inside the frame. It makes its mid-run writes through the normal write port. It then compares every output on every cycle of three frames and of the idle period that follows against values computed from the cycle index.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic {ST_IDLE, ST_RUN} vtg_state_e;

    localparam logic [ADDR_W-1:0] A_LPER  = 4'd0;
    localparam logic [ADDR_W-1:0] A_HSW   = 4'd1;
    localparam logic [ADDR_W-1:0] A_HBEG  = 4'd2;
    localparam logic [ADDR_W-1:0] A_HFIN  = 4'd3;
    localparam logic [ADDR_W-1:0] A_FPER  = 4'd4;
    localparam logic [ADDR_W-1:0] A_VLEN  = 4'd5;
    localparam logic [ADDR_W-1:0] A_VBEG  = 4'd6;
    localparam logic [ADDR_W-1:0] A_VFIN  = 4'd7;
    localparam logic [ADDR_W-1:0] A_POL   = 4'd8;
    localparam logic [ADDR_W-1:0] A_FILL  = 4'd9;
    localparam logic [ADDR_W-1:0] A_BORD  = 4'd10;
    localparam logic [ADDR_W-1:0] A_RUN   = 4'd11;
    localparam logic [ADDR_W-1:0] A_CNTEN = 4'd12;
    localparam logic [ADDR_W-1:0] A_FMT   = 4'd13;
    localparam logic [ADDR_W-1:0] A_LCNT  = 4'd14;
    localparam logic [ADDR_W-1:0] A_FCNT  = 4'd15;

    localparam int unsigned RST_LPER = 8;
    localparam int unsigned RST_HSW  = 2;
    localparam int unsigned RST_HBEG = 3;
    localparam int unsigned RST_HFIN = 6;
    localparam int unsigned RST_FPER = 48;
    localparam int unsigned RST_VLEN = 8;
    localparam int unsigned RST_VBEG = 16;
    localparam int unsigned RST_VFIN = 39;
    localparam int unsigned RST_FILL = 32'hFF;
    localparam logic [15:0] RST_FMT  = 16'h213F;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int unsigned H_W  = 12,
    parameter int unsigned F_W  = 24,
    parameter int unsigned C_W  = 24,
    parameter int unsigned FC_W = 16,
    parameter int unsigned DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              load,
    input  logic [H_W-1:0]    line_cnt,
    input  logic [FC_W-1:0]   frame_cnt,
    output logic              eng_en,
    output logic [1:0]        cnt_en,
    output logic [H_W-1:0]    a_lper,
    output logic [H_W-1:0]    a_hsw,
    output logic [H_W-1:0]    a_hbeg,
    output logic [H_W-1:0]    a_hfin,
    output logic [F_W-1:0]    a_fper,
    output logic [F_W-1:0]    a_vlen,
    output logic [F_W-1:0]    a_vbeg,
    output logic [F_W-1:0]    a_vfin,
    output logic [1:0]        a_pol,
    output logic [C_W-1:0]    a_fill,
    output logic [C_W-1:0]    a_bord
);
    logic [H_W-1:0] s_lper, s_hsw, s_hbeg, s_hfin;
    logic [F_W-1:0] s_fper, s_vlen, s_vbeg, s_vfin;
    logic [1:0]     s_pol;
    logic [C_W-1:0] s_fill, s_bord;
    logic [15:0]    s_fmt;

    // pending copy, written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_lper <= H_W'(RST_LPER);
            s_hsw  <= H_W'(RST_HSW);
            s_hbeg <= H_W'(RST_HBEG);
            s_hfin <= H_W'(RST_HFIN);
            s_fper <= F_W'(RST_FPER);
            s_vlen <= F_W'(RST_VLEN);
            s_vbeg <= F_W'(RST_VBEG);
            s_vfin <= F_W'(RST_VFIN);
            s_pol  <= '0;
            s_fill <= C_W'(RST_FILL);
            s_bord <= '0;
            s_fmt  <= RST_FMT;
            eng_en <= 1'b0;
            cnt_en <= 2'b00;
        end else if (wr_en) begin
            case (wr_addr)
                A_LPER:  s_lper <= wr_data[H_W-1:0];
                A_HSW:   s_hsw  <= wr_data[H_W-1:0];
                A_HBEG:  s_hbeg <= wr_data[H_W-1:0];
                A_HFIN:  s_hfin <= wr_data[H_W-1:0];
                A_FPER:  s_fper <= wr_data[F_W-1:0];
                A_VLEN:  s_vlen <= wr_data[F_W-1:0];
                A_VBEG:  s_vbeg <= wr_data[F_W-1:0];
                A_VFIN:  s_vfin <= wr_data[F_W-1:0];
                A_POL:   s_pol  <= wr_data[1:0];
                A_FILL:  s_fill <= wr_data[C_W-1:0];
                A_BORD:  s_bord <= wr_data[C_W-1:0];
                A_RUN:   eng_en <= wr_data[0];
                A_CNTEN: cnt_en <= wr_data[1:0];
                A_FMT:   s_fmt  <= wr_data[15:0];
                default: ;
            endcase
        end
    end

    // working copy, taken at frame wrap or while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lper <= H_W'(RST_LPER);
            a_hsw  <= H_W'(RST_HSW);
            a_hbeg <= H_W'(RST_HBEG);
            a_hfin <= H_W'(RST_HFIN);
            a_fper <= F_W'(RST_FPER);
            a_vlen <= F_W'(RST_VLEN);
            a_vbeg <= F_W'(RST_VBEG);
            a_vfin <= F_W'(RST_VFIN);
            a_pol  <= '0;
            a_fill <= C_W'(RST_FILL);
            a_bord <= '0;
        end else if (load) begin
            a_lper <= s_lper;
            a_hsw  <= s_hsw;
            a_hbeg <= s_hbeg;
            a_hfin <= s_hfin;
            a_fper <= s_fper;
            a_vlen <= s_vlen;
            a_vbeg <= s_vbeg;
            a_vfin <= s_vfin;
            a_pol  <= s_pol;
            a_fill <= s_fill;
            a_bord <= s_bord;
        end
    end

    always_comb begin
        case (rd_addr)
            A_LPER:  rd_data = DW'(s_lper);
            A_HSW:   rd_data = DW'(s_hsw);
            A_HBEG:  rd_data = DW'(s_hbeg);
            A_HFIN:  rd_data = DW'(s_hfin);
            A_FPER:  rd_data = DW'(s_fper);
            A_VLEN:  rd_data = DW'(s_vlen);
            A_VBEG:  rd_data = DW'(s_vbeg);
            A_VFIN:  rd_data = DW'(s_vfin);
            A_POL:   rd_data = DW'(s_pol);
            A_FILL:  rd_data = DW'(s_fill);
            A_BORD:  rd_data = DW'(s_bord);
            A_RUN:   rd_data = DW'(eng_en);
            A_CNTEN: rd_data = DW'(cnt_en);
            A_FMT:   rd_data = DW'(s_fmt);
            A_LCNT:  rd_data = DW'(line_cnt);
            default: rd_data = DW'(frame_cnt);
        endcase
    end
endmodule

// File: rtl/vtg_seq.sv
module vtg_seq
    import vtg_pkg::*;
#(
    parameter int unsigned H_W  = 12,
    parameter int unsigned F_W  = 24,
    parameter int unsigned FC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eng_en,
    input  logic [1:0]      cnt_en,
    input  logic [H_W-1:0]  line_per,
    input  logic [F_W-1:0]  frame_per,
    output logic            running,
    output logic            load,
    output logic [F_W-1:0]  pcnt,
    output logic [H_W-1:0]  hpos,
    output logic [H_W-1:0]  line_cnt,
    output logic [FC_W-1:0] frame_cnt
);
    vtg_state_e state, nxt;
    logic frame_wrap, line_wrap;

    assign frame_wrap = (state == ST_RUN) && (pcnt == frame_per - F_W'(1));
    assign line_wrap  = (state == ST_RUN) && (hpos == line_per - H_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (eng_en) nxt = ST_RUN;                  // IDLE_TO_RUN
            ST_RUN:  if (frame_wrap && !eng_en) nxt = ST_IDLE;  // RUN_TO_IDLE
        endcase
    end

    always_comb begin
        running = (state == ST_RUN);
        load    = (state == ST_IDLE) || frame_wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt      <= '0;
            hpos      <= '0;
            line_cnt  <= '0;
            frame_cnt <= '0;
        end else if (state == ST_IDLE) begin
            pcnt <= '0;
            hpos <= '0;
        end else begin
            pcnt <= frame_wrap ? '0 : pcnt + F_W'(1);
            hpos <= (frame_wrap || line_wrap) ? '0 : hpos + H_W'(1);
            if (cnt_en[0]) begin
                if (frame_wrap)     line_cnt <= '0;
                else if (line_wrap) line_cnt <= line_cnt + H_W'(1);
            end
            if (cnt_en[1] && frame_wrap) frame_cnt <= frame_cnt + FC_W'(1);
        end
    end
endmodule

// File: rtl/vtg_out.sv
module vtg_out #(
    parameter int unsigned H_W = 12,
    parameter int unsigned F_W = 24,
    parameter int unsigned C_W = 24
) (
    input  logic           running,
    input  logic [F_W-1:0] pcnt,
    input  logic [H_W-1:0] hpos,
    input  logic [H_W-1:0] hsw,
    input  logic [H_W-1:0] hbeg,
    input  logic [H_W-1:0] hfin,
    input  logic [F_W-1:0] vlen,
    input  logic [F_W-1:0] vbeg,
    input  logic [F_W-1:0] vfin,
    input  logic [1:0]     pol,
    input  logic [C_W-1:0] fill,
    input  logic [C_W-1:0] bord,
    input  logic [C_W-1:0] pix_i,
    input  logic           pix_valid_i,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           de_o,
    output logic [C_W-1:0] pix_o
);
    logic h_act, v_act, in_h, in_v;

    always_comb begin
        h_act   = running && (hpos < hsw);
        v_act   = running && (pcnt < vlen);
        in_h    = (hpos >= hbeg) && (hpos <= hfin);
        in_v    = (pcnt >= vbeg) && (pcnt <= vfin);
        hsync_o = h_act ^ pol[0];
        vsync_o = v_act ^ pol[1];
        de_o    = running && in_h && in_v;
        if (!de_o)            pix_o = bord;
        else if (pix_valid_i) pix_o = pix_i;
        else                  pix_o = fill;
    end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
    import vtg_pkg::*;
#(
    parameter int unsigned H_W  = 12,
    parameter int unsigned F_W  = 24,
    parameter int unsigned C_W  = 24,
    parameter int unsigned FC_W = 16,
    parameter int unsigned DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [C_W-1:0]    pix_i,
    input  logic              pix_valid_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [C_W-1:0]    pix_o
);
    logic            eng_en, load, running;
    logic [1:0]      cnt_en, a_pol;
    logic [H_W-1:0]  a_lper, a_hsw, a_hbeg, a_hfin, hpos, line_cnt;
    logic [F_W-1:0]  a_fper, a_vlen, a_vbeg, a_vfin, pcnt;
    logic [C_W-1:0]  a_fill, a_bord;
    logic [FC_W-1:0] frame_cnt;

    vtg_regs #(.H_W(H_W), .F_W(F_W), .C_W(C_W), .FC_W(FC_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .load(load), .line_cnt(line_cnt), .frame_cnt(frame_cnt),
        .eng_en(eng_en), .cnt_en(cnt_en),
        .a_lper(a_lper), .a_hsw(a_hsw), .a_hbeg(a_hbeg), .a_hfin(a_hfin),
        .a_fper(a_fper), .a_vlen(a_vlen), .a_vbeg(a_vbeg), .a_vfin(a_vfin),
        .a_pol(a_pol), .a_fill(a_fill), .a_bord(a_bord)
    );

    vtg_seq #(.H_W(H_W), .F_W(F_W), .FC_W(FC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cnt_en(cnt_en),
        .line_per(a_lper), .frame_per(a_fper), .running(running),
        .load(load), .pcnt(pcnt), .hpos(hpos), .line_cnt(line_cnt),
        .frame_cnt(frame_cnt)
    );

    vtg_out #(.H_W(H_W), .F_W(F_W), .C_W(C_W)) u_out (
        .running(running), .pcnt(pcnt), .hpos(hpos),
        .hsw(a_hsw), .hbeg(a_hbeg), .hfin(a_hfin),
        .vlen(a_vlen), .vbeg(a_vbeg), .vfin(a_vfin),
        .pol(a_pol), .fill(a_fill), .bord(a_bord),
        .pix_i(pix_i), .pix_valid_i(pix_valid_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o)
    );
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk #(
    parameter int unsigned F_W  = 24,
    parameter int unsigned C_W  = 24,
    parameter int unsigned FC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            running,
    input logic [F_W-1:0]  pcnt,
    input logic [F_W-1:0]  frame_per,
    input logic [FC_W-1:0] frame_cnt,
    input logic [1:0]      pol,
    input logic [C_W-1:0]  fill,
    input logic            pix_valid_i,
    input logic            hsync_o,
    input logic            vsync_o,
    input logic            de_o,
    input logic [C_W-1:0]  pix_o
);
    p_pcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (pcnt < frame_per));

    p_no_de_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !de_o);

    p_fill_colour_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && !pix_valid_i) |-> (pix_o == fill));

    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> ((hsync_o == pol[0]) && (vsync_o == pol[1])));

    p_stop_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> ($past(pcnt) == $past(frame_per) - F_W'(1)));

    p_frame_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != $past(frame_cnt)) |-> (frame_cnt == $past(frame_cnt) + FC_W'(1)));
endmodule

bind vid_timing_gen vtg_chk #(.F_W(F_W), .C_W(C_W), .FC_W(FC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .pcnt(pcnt),
    .frame_per(a_fper), .frame_cnt(frame_cnt), .pol(a_pol), .fill(a_fill),
    .pix_valid_i(pix_valid_i), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pix_o(pix_o)
);

// File: tb/sim_vid_timing_gen.sv
`timescale 1ns/1ps
module sim_vid_timing_gen;
    localparam int L = 10;
    localparam int F = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [23:0] pix_i = '0;
    logic        pix_valid_i = 1'b0;
    logic        hsync_o, vsync_o, de_o;
    logic [23:0] pix_o;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vid_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_i(pix_i), .pix_valid_i(pix_valid_i), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pix_valid_i = 1'b1; pix_i = 24'h777777;
        #1;
        // R1 reset state
        chk("R1 hsync", {31'd0, hsync_o}, 0);
        chk("R1 vsync", {31'd0, vsync_o}, 0);
        chk("R1 de", {31'd0, de_o}, 0);
        chk("R1 pix", {8'd0, pix_o}, 0);
        rd(0, "R1 lper", 8);   rd(1, "R1 hsw", 2);
        rd(2, "R1 hbeg", 3);   rd(3, "R1 hfin", 6);
        rd(4, "R1 fper", 48);  rd(5, "R1 vlen", 8);
        rd(6, "R1 vbeg", 16);  rd(7, "R1 vfin", 39);
        rd(8, "R1 pol", 0);    rd(9, "R1 fill", 32'hFF);
        rd(10, "R1 bord", 0);  rd(11, "R1 en", 0);
        rd(12, "R1 cnten", 0); rd(13, "R1 fmt", 32'h213F);
        rd(14, "R1 lcnt", 0);  rd(15, "R1 fcnt", 0);

        // program a small raster while idle
        wr(0, L);  wr(1, 3);  wr(2, 4);  wr(3, 8);
        wr(4, F);  wr(5, 10); wr(6, 20); wr(7, 39);
        wr(10, 32'hAA); wr(12, 3); wr(13, 32'h212A);
        rd(13, "R10 fmt", 32'h212A);
        rd(2, "R10 hbeg", 4);
        rd(12, "R10 cnten", 3);
        #1;
        chk("R5 idle border", {8'd0, pix_o}, 32'hAA);
        wr(11, 1);  // R7 start

        for (int k = 0; k < 3 * F + 6; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (k == 25)        begin wr_en = 1'b1; wr_addr = 8;  wr_data = 3; end
            if (k == 26)        begin wr_en = 1'b1; wr_addr = 9;  wr_data = 32'h123456; end
            if (k == 2 * F + 2) begin wr_en = 1'b1; wr_addr = 12; wr_data = 2; end
            if (k == 2 * F + 10) begin wr_en = 1'b1; wr_addr = 11; wr_data = 0; end
            pix_valid_i = (k % 4) != 1;
            pix_i = 24'(k * 7 + 1);
            #1;
            begin
                int p, h, pol, uf;
                bit run, hs, vs, de;
                logic [23:0] px;
                run = k < 3 * F;
                p = k % F; h = k % L;
                pol = (k >= F) ? 3 : 0;
                uf  = (k >= F) ? 32'h123456 : 32'hFF;
                hs = run && (h < 3);
                vs = run && (p < 10);
                de = run && p >= 20 && p <= 39 && h >= 4 && h <= 8;
                px = de ? (pix_valid_i ? pix_i : 24'(uf)) : 24'hAA;
                chk($sformatf("R2 R6 hsync k=%0d", k), {31'd0, hsync_o}, {31'd0, hs ^ pol[0]});
                chk($sformatf("R3 R6 vsync k=%0d", k), {31'd0, vsync_o}, {31'd0, vs ^ pol[1]});
                chk($sformatf("R4 R7 de k=%0d", k), {31'd0, de_o}, {31'd0, de});
                chk($sformatf("R5 R8 pix k=%0d", k), {8'd0, pix_o}, {8'd0, px});
                rd(14, $sformatf("R9 lcnt k=%0d", k), (k >= 2 * F) ? 0 : p / L);
                rd(15, $sformatf("R9 fcnt k=%0d", k), run ? k / F : 3);
                if (k == 26) rd(8, "R8 pol readback", 3);
                if (k == 27) rd(9, "R8 fill readback", 32'h123456);
            end
        end
        wr_en = 1'b0;
        rd(11, "R7 en readback", 0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule